// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that sits beside a pair of free-running 16-bit counters. It does not count. It watches the count of a chosen time base and drives a single output pin with set/reset flip-flop logic. A 3-bit mode field picks what a match does. The pin can be set, cleared or toggled on a primary match. It can give one pulse, or a repeating pulse, bounded by a primary and a secondary compare value. It can also run as a pulse-width modulator, where the period strobe of the time base starts each cycle.

Software reaches the block through three load strobes, one each for the primary compare value, the secondary compare value and the mode. A select input picks one of the two 16-bit counts. A width input joins both counts into one 32-bit count. In the PWM mode with fault detection, an external active-low fault input drives the pin low and withdraws its output enable. The fault stays latched until the mode is loaded again. Compare and fault events give a one-cycle interrupt pulse.

Top module: `tmr_cmp_channel`

## Requirements
- R1: During reset `pin_out`, `pin_oe`, `irq_pulse` and `fault_sts` are all 0.
- R2: Mode 3'b000 keeps `pin_out` and `pin_oe` low. Every other mode drives `pin_oe` high unless a fault is latched.
- R3: With `wide_mode`=0, `tb_sel`=0 compares `tmr_a` (period strobe `prd_a`) and `tb_sel`=1 compares `tmr_b` (period strobe `prd_b`). Only bits [15:0] of the compare values are used, so the unselected count has no effect.
- R4: With `wide_mode`=1 the count is {`tmr_b`,`tmr_a`}, the full 32-bit compare values are used, and `prd_a` is the period strobe.
- R5: Modes 3'b001, 3'b010 and 3'b011 set, clear or toggle the pin on a primary match and pulse `irq_pulse`. The result appears on the first rising edge that samples the matching count. A register load takes effect from the following cycle.
- R6: A match that persists over several consecutive cycles counts as one event.
- R7: Mode 3'b100 sets the pin on a primary match and clears it on a secondary match, with an interrupt pulse at the clear. The secondary match has priority. After that clear, no match has any effect until the mode is loaded again.
- R8: Mode 3'b101 behaves as R7 but repeats on every later primary/secondary match pair.
- R9: In modes 3'b110 and 3'b111 the period strobe copies the secondary value into the primary register. On the same edge the pin goes high if that value is nonzero and low if it is zero. A primary match clears the pin. This mode gives no interrupt pulse apart from the fault pulse.
- R10: In mode 3'b111, `fault_n` is synchronized with two flops. On the third rising edge after it goes low, `pin_out` and `pin_oe` drop and `fault_sts` rises, with a single interrupt pulse. `fault_sts` holds until a mode load. Mode 3'b110 ignores `fault_n`.
- R11: Any change of `tb_sel` or `wide_mode` clears the pin on the edge that samples the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_a | input | 16 | Count of time base A (low half in 32-bit mode) |
| tmr_b | input | 16 | Count of time base B (high half in 32-bit mode) |
| prd_a | input | 1 | Period-match strobe of time base A |
| prd_b | input | 1 | Period-match strobe of time base B |
| wide_mode | input | 1 | Join both counts into one 32-bit time base |
| tb_sel | input | 1 | 16-bit time-base select: 0 = A, 1 = B |
| pri_wdata | input | 32 | Load value for the primary compare register |
| pri_we | input | 1 | Primary compare load strobe |
| sec_wdata | input | 32 | Load value for the secondary compare register |
| sec_we | input | 1 | Secondary compare load strobe |
| mode_wdata | input | 3 | Load value for the mode field |
| mode_we | input | 1 | Mode load strobe; also clears the fault and single-pulse state |
| fault_n | input | 1 | Asynchronous active-low fault input |
| pin_out | output | 1 | Output pin level |
| pin_oe | output | 1 | Output pin enable |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| fault_sts | output | 1 | Latched fault status |

## Verification
Every pin change and interrupt pulse appears at the rising edge that samples the matching count or strobe. Each stimulus is therefore paired with one expected result that is checked one nanosecond after the next rising edge. Loads of the compare values and the mode act one cycle later, so those cycles are applied without a check. The fault path is the exception because its two synchronizer flops add latency. The bench holds expectations for the two cycles after `fault_n` falls and only looks for the shutdown on the third edge. The PWM expectations come from a small period/duty model in the bench, stepped with the same count sequence the bench drives.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [2:0] {
    M_OFF  = 3'b000,
    M_SET  = 3'b001,
    M_CLR  = 3'b010,
    M_TGL  = 3'b011,
    M_ONE  = 3'b100,
    M_CONT = 3'b101,
    M_PWM  = 3'b110,
    M_PWMF = 3'b111
  } tcc_mode_e;
endpackage

// File: rtl/tcc_timebase.sv
module tcc_timebase #(
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   tmr_a,
  input  logic [TW-1:0]   tmr_b,
  input  logic            prd_a,
  input  logic            prd_b,
  input  logic            wide,
  input  logic            tsel,
  output logic [2*TW-1:0] cnt,
  output logic            prd,
  output logic            base_chg
);
  localparam int CW = 2 * TW;

  logic wide_q, tsel_q;

  // count and strobe selection
  always_comb begin
    if (wide) begin
      cnt = {tmr_b, tmr_a};
      prd = prd_a;
    end else if (tsel) begin
      cnt = {{(CW-TW){1'b0}}, tmr_b};
      prd = prd_b;
    end else begin
      cnt = {{(CW-TW){1'b0}}, tmr_a};
      prd = prd_a;
    end
  end

  assign base_chg = (wide != wide_q) || (tsel != tsel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      tsel_q <= 1'b0;
    end else begin
      wide_q <= wide;
      tsel_q <= tsel;
    end
  end
endmodule

// File: rtl/tcc_match.sv
module tcc_match #(
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*TW-1:0] cnt,
  input  logic [2*TW-1:0] cmp_val,
  input  logic            wide,
  output logic            hit
);
  localparam int CW = 2 * TW;

  logic [CW-1:0] cmp_m;
  logic          eq, eq_q;

  assign cmp_m = wide ? cmp_val : {{(CW-TW){1'b0}}, cmp_val[TW-1:0]};
  assign eq    = (cnt == cmp_m);
  assign hit   = eq && !eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end

  // R6: a persisting equality yields one event only
  p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/tcc_sync.sv
module tcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel
  import tcc_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   tmr_a,
  input  logic [TW-1:0]   tmr_b,
  input  logic            prd_a,
  input  logic            prd_b,
  input  logic            wide_mode,
  input  logic            tb_sel,
  input  logic [2*TW-1:0] pri_wdata,
  input  logic            pri_we,
  input  logic [2*TW-1:0] sec_wdata,
  input  logic            sec_we,
  input  logic [2:0]      mode_wdata,
  input  logic            mode_we,
  input  logic            fault_n,
  output logic            pin_out,
  output logic            pin_oe,
  output logic            irq_pulse,
  output logic            fault_sts
);
  localparam int CW   = 2 * TW;
  localparam int NCMP = 2;

  tcc_mode_e     mode_q, mode_n;
  logic [CW-1:0] pri_q, pri_n, sec_q, sec_n, sec_m;
  logic          pin_q, pin_n, irq_q, irq_n, done_q, done_n, flt_q, flt_n;
  logic          pri_en, sec_en, mode_en;

  logic [CW-1:0] cnt;
  logic          prd, base_chg, flt_s;
  logic [CW-1:0] cmp_vals [NCMP];
  logic [NCMP-1:0] hits;
  logic          hit_p, hit_s;

  tcc_timebase #(.TW(TW)) u_tb (
    .clk(clk), .rst_n(rst_n), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .prd_a(prd_a), .prd_b(prd_b), .wide(wide_mode), .tsel(tb_sel),
    .cnt(cnt), .prd(prd), .base_chg(base_chg)
  );

  assign cmp_vals[0] = pri_q;
  assign cmp_vals[1] = sec_q;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    tcc_match #(.TW(TW)) u_m (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_val(cmp_vals[g]),
      .wide(wide_mode), .hit(hits[g])
    );
  end

  assign hit_p = hits[0];
  assign hit_s = hits[1];

  tcc_sync #(.STAGES(SYNC_STAGES)) u_fs (
    .clk(clk), .rst_n(rst_n), .d(fault_n), .q(flt_s)
  );

  assign sec_m = wide_mode ? sec_q : {{(CW-TW){1'b0}}, sec_q[TW-1:0]};

  // next-state logic
  always_comb begin
    pri_n  = pri_q;
    sec_n  = sec_q;
    mode_n = mode_q;
    pin_n  = pin_q;
    irq_n  = 1'b0;
    done_n = done_q;
    flt_n  = flt_q;
    pri_en = pri_we;
    if (pri_we) pri_n = pri_wdata;
    if (sec_we) sec_n = sec_wdata;
    if (mode_we) mode_n = tcc_mode_e'(mode_wdata);

    case (mode_q)
      M_OFF: pin_n = 1'b0;
      M_SET: if (hit_p) begin pin_n = 1'b1; irq_n = 1'b1; end
      M_CLR: if (hit_p) begin pin_n = 1'b0; irq_n = 1'b1; end
      M_TGL: if (hit_p) begin pin_n = !pin_q; irq_n = 1'b1; end
      M_ONE, M_CONT: begin
        if (!done_q) begin
          if (hit_s) begin
            pin_n = 1'b0;
            irq_n = 1'b1;
            if (mode_q == M_ONE) done_n = 1'b1;
          end else if (hit_p) begin
            pin_n = 1'b1;
          end
        end
      end
      M_PWM, M_PWMF: begin
        if (prd) begin
          pri_en = 1'b1;
          pri_n  = sec_q;
          pin_n  = |sec_m;
        end else if (hit_p) begin
          pin_n = 1'b0;
        end
        if (mode_q == M_PWMF) begin
          if (!flt_s) begin
            pin_n = 1'b0;
            if (!flt_q) begin
              flt_n = 1'b1;
              irq_n = 1'b1;
            end
          end
          if (flt_q) pin_n = 1'b0;
        end
      end
      default: pin_n = 1'b0;
    endcase

    if (mode_we) begin
      done_n = 1'b0;
      flt_n  = 1'b0;
    end
    if (base_chg) pin_n = 1'b0;
  end

  assign sec_en  = sec_we;
  assign mode_en = mode_we;

  // register process with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q  <= '0;
      sec_q  <= '0;
      mode_q <= M_OFF;
      pin_q  <= 1'b0;
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      if (pri_en)  pri_q  <= pri_n;
      if (sec_en)  sec_q  <= sec_n;
      if (mode_en) mode_q <= mode_n;
      pin_q  <= pin_n;
      irq_q  <= irq_n;
      done_q <= done_n;
      flt_q  <= flt_n;
    end
  end

  assign pin_out   = pin_q;
  assign pin_oe    = (mode_q != M_OFF) && !flt_q;
  assign irq_pulse = irq_q;
  assign fault_sts = flt_q;

  // R2: a disabled channel keeps the pin low
  p_off_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF && $past(mode_q == M_OFF)) |-> !pin_out);

  // R10: a latched fault silences and releases the pin
  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |-> (!pin_out && !pin_oe));

  // R10: fault status holds until a mode load
  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q && !mode_we) |=> flt_q);

  // R11: time-base change clears the pin
  p_base_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    base_chg |=> !pin_out);

  // R7: finished single pulse keeps the pin low
  p_single_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ONE && done_q && !mode_we) |=> !pin_out);
endmodule

// File: tb/sim_tmr_cmp_channel.sv
`timescale 1ns/1ps
module sim_tmr_cmp_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] tmr_a, tmr_b;
  logic        prd_a, prd_b, wide_mode, tb_sel;
  logic [31:0] pri_wdata, sec_wdata;
  logic        pri_we, sec_we, mode_we, fault_n;
  logic [2:0]  mode_wdata;
  logic        pin_out, pin_oe, irq_pulse, fault_sts;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    logic  pin, oe, irq, flt;
    bit    chk;
    string tag;
  } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  tmr_cmp_channel u0 (
    .clk(clk), .rst_n(rst_n), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .prd_a(prd_a), .prd_b(prd_b), .wide_mode(wide_mode), .tb_sel(tb_sel),
    .pri_wdata(pri_wdata), .pri_we(pri_we), .sec_wdata(sec_wdata),
    .sec_we(sec_we), .mode_wdata(mode_wdata), .mode_we(mode_we),
    .fault_n(fault_n), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_pulse(irq_pulse), .fault_sts(fault_sts)
  );

  // monitor: compares one expectation per clock, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() != 0) begin
        exp_t e;
        e = sbq.pop_front();
        if (e.chk) begin
          vectors++;
          if (pin_out !== e.pin || pin_oe !== e.oe ||
              irq_pulse !== e.irq || fault_sts !== e.flt) begin
            miscompares++;
            $display("FAIL %s: pin/oe/irq/flt got %b%b%b%b exp %b%b%b%b",
                     e.tag, pin_out, pin_oe, irq_pulse, fault_sts,
                     e.pin, e.oe, e.irq, e.flt);
          end
        end
      end
    end
  end

  // driver: inputs are already set; push expectation and advance one cycle
  task automatic cyc(input logic p, input logic o, input logic i,
                     input logic f, input bit c, input string t);
    exp_t e;
    e.pin = p; e.oe = o; e.irq = i; e.flt = f; e.chk = c; e.tag = t;
    sbq.push_back(e);
    @(negedge clk);
  endtask

  task automatic tk(input logic [15:0] a, input logic [15:0] b,
                    input logic pa, input logic p, input logic o,
                    input logic i, input logic f, input string t);
    tmr_a = a; tmr_b = b; prd_a = pa; prd_b = 1'b0;
    cyc(p, o, i, f, 1'b1, t);
  endtask

  task automatic wr(input bit wp, input logic [31:0] vp, input bit ws,
                    input logic [31:0] vs, input bit wm, input logic [2:0] vm);
    tmr_a = '0; tmr_b = '0; prd_a = 1'b0; prd_b = 1'b0;
    pri_we = wp; pri_wdata = vp; sec_we = ws; sec_wdata = vs;
    mode_we = wm; mode_wdata = vm;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "load");
    pri_we = 1'b0; sec_we = 1'b0; mode_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      tmr_a = '0; tmr_b = '0; prd_a = 1'b0; prd_b = 1'b0;
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "idle");
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic mp;
    logic [15:0] act, secm;
    rst_n = 1'b0; tmr_a = '0; tmr_b = '0; prd_a = 1'b0; prd_b = 1'b0;
    wide_mode = 1'b0; tb_sel = 1'b0; pri_wdata = '0; sec_wdata = '0;
    pri_we = 1'b0; sec_we = 1'b0; mode_wdata = '0; mode_we = 1'b0;
    fault_n = 1'b1;
    @(negedge clk);
    cyc(0, 0, 0, 0, 1, "R1 reset state");
    cyc(0, 0, 0, 0, 1, "R1 reset state");
    rst_n = 1'b1;
    tk(5, 0, 0, 0, 0, 0, 0, "R2 disabled holds low");

    // set / clear / toggle on primary match
    wr(1, 32'd5, 0, 0, 1, 3'b001);
    tk(3, 0, 0, 0, 1, 0, 0, "R5 set waits");
    tk(5, 0, 0, 1, 1, 1, 0, "R5 set on match");
    tk(5, 0, 0, 1, 1, 0, 0, "R6 held match one event");
    tk(6, 0, 0, 1, 1, 0, 0, "R5 set holds");
    wr(0, 0, 0, 0, 1, 3'b010);
    tk(5, 0, 0, 0, 1, 1, 0, "R5 clear on match");
    wr(0, 0, 0, 0, 1, 3'b011);
    tk(5, 0, 0, 1, 1, 1, 0, "R5 toggle");
    tk(5, 0, 0, 1, 1, 0, 0, "R6 no retoggle");
    tk(5, 0, 0, 1, 1, 0, 0, "R6 no retoggle");
    tk(6, 0, 0, 1, 1, 0, 0, "R5 toggle idle");
    tk(5, 0, 0, 0, 1, 1, 0, "R5 toggle back");
    tk(7, 0, 0, 0, 1, 0, 0, "R5 toggle idle");
    tk(5, 0, 0, 1, 1, 1, 0, "R5 toggle up");

    // time-base select and width
    tb_sel = 1'b1;
    tk(5, 0, 0, 0, 1, 0, 0, "R11 select change clears");
    tk(5, 0, 0, 0, 1, 0, 0, "R3 unselected count ignored");
    wr(1, 32'h0001_0005, 0, 0, 0, 3'b000);
    tk(0, 5, 0, 1, 1, 1, 0, "R3 count B low-half match");
    tk(0, 6, 0, 1, 1, 0, 0, "R3 count B idle");
    wide_mode = 1'b1;
    tk(5, 0, 0, 0, 1, 0, 0, "R11 width change clears");
    tk(5, 1, 0, 1, 1, 1, 0, "R4 full 32-bit match");
    tk(5, 0, 0, 1, 1, 0, 0, "R4 low half alone no match");
    wide_mode = 1'b0; tb_sel = 1'b0;
    tk(0, 0, 0, 0, 1, 0, 0, "R11 back to 16-bit clears");

    // single pulse
    wr(1, 32'd10, 1, 32'd20, 1, 3'b100);
    tk(10, 0, 0, 1, 1, 0, 0, "R7 start on primary");
    tk(15, 0, 0, 1, 1, 0, 0, "R7 pulse held");
    tk(20, 0, 0, 0, 1, 1, 0, "R7 end with irq");
    tk(10, 0, 0, 0, 1, 0, 0, "R7 no second pulse");
    tk(20, 0, 0, 0, 1, 0, 0, "R7 no irq after done");

    // continuous pulses
    wr(0, 0, 0, 0, 1, 3'b101);
    for (int k = 0; k < 2; k++) begin
      tk(10, 0, 0, 1, 1, 0, 0, "R8 repeat start");
      tk(20, 0, 0, 0, 1, 1, 0, "R8 repeat end irq");
    end

    // PWM without fault detection, model of period and duty
    wr(1, 32'd4, 1, 32'd4, 1, 3'b110);
    mp = 1'b0; act = 16'd4; secm = 16'd4;
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < 8; t++) begin
        if (p == 1 && t == 3) begin sec_we = 1'b1; sec_wdata = 32'd0; end
        if (p == 2 && t == 3) begin sec_we = 1'b1; sec_wdata = 32'd2; end
        fault_n = (p == 3) ? 1'b0 : 1'b1;
        if (t == 7) begin act = secm; mp = (secm != 0); end
        else if (t[15:0] == act) mp = 1'b0;
        tk(t[15:0], 0, (t == 7), mp, 1, 0, 0, "R9 PWM period/duty, R10 fault ignored");
        if (sec_we) begin secm = sec_wdata[15:0]; sec_we = 1'b0; end
      end
    end
    fault_n = 1'b1;
    idle(3);

    // PWM with fault detection
    wr(1, 32'd4, 1, 32'd4, 1, 3'b111);
    tk(7, 0, 1, 1, 1, 0, 0, "R9 strobe starts period");
    tk(0, 0, 0, 1, 1, 0, 0, "R9 high in period");
    fault_n = 1'b0;
    tk(1, 0, 0, 1, 1, 0, 0, "R10 sync delay 1");
    tk(2, 0, 0, 1, 1, 0, 0, "R10 sync delay 2");
    tk(3, 0, 0, 0, 0, 1, 1, "R10 fault shuts output");
    fault_n = 1'b1;
    tk(4, 0, 0, 0, 0, 0, 1, "R10 single irq");
    tk(5, 0, 0, 0, 0, 0, 1, "R10 sticky");
    tk(6, 0, 0, 0, 0, 0, 1, "R10 sticky");
    tk(7, 0, 1, 0, 0, 0, 1, "R10 strobe blocked under fault");
    wr(0, 0, 0, 0, 1, 3'b111);
    tk(1, 0, 0, 0, 1, 0, 0, "R10 cleared by mode load");
    tk(7, 0, 1, 1, 1, 0, 0, "R10 output resumes");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule